// File: doc/BRIEF.md
# Warm-Boot Reconfiguration Command Sequencer

This block sits in user logic and asks the device's configuration engine to reboot from a different flash image. It drives a 32-bit internal configuration write port, which uses an active-low select, an active-low write/read direction line and a write data bus. Between requests it holds that port at rest and waits for a one-cycle trigger from the surrounding logic.

On a trigger the block captures a 2-bit image number. It then lowers the direction line and, one edge later, the select line. With select low it streams a fixed eight-word command packet, one word per clock. The packet holds a dummy word and the synchronisation word, then a write of the warm-boot start address and a write of the reboot command, with no-op words between them. The image number is placed in the start-address word.

Each word is driven with its bits mirrored inside every byte, because the port expects that lane order. When the packet is done the block raises select, then raises direction on a later edge, then raises a done flag. The done flag stays set until the next trigger is taken. The port is write-only: its busy and read-data outputs are not used.

Top module: `warm_boot_seq`

## Requirements
- R1: A synchronous active-high reset drives `cfg_sel_n` and `cfg_dir_n` to 1, `cfg_data` to 0, `seq_done` to 0 and `seq_busy` to 0.
- R2: While idle and `trig` is low, the outputs stay at rest (select 1, direction 1, data 0) whatever `rev_sel` does.
- R3: On the clock edge that samples `trig` high in idle, `cfg_dir_n` falls. `cfg_sel_n` falls on the next edge. The two lines never change on the same edge, and select is low only while direction is low.
- R4: While `cfg_sel_n` is low, exactly eight words are presented, one per clock. In logical order they are FFFFFFFF, AA995566, 20000000, 30020001, the start-address word, 30008001, 0000000F and 20000000 (hex).
- R5: Every word is driven with bit i of each byte moved to bit 7-i of the same byte. For example, AA995566 is driven as 5599AA66 and 30020001 as 0C400080.
- R6: The logical start-address word is built from three fields. Bits 28:27 hold the image number, bit 26 is 1, bits 25:0 hold `START_ADDR` (default 0), and bits 31:29 are 0. With the default, images 0 to 3 are driven as 20000000, 30000000, 28000000 and 38000000.
- R7: `rev_sel` is sampled on the trigger edge, and that value is used for the whole packet even if `rev_sel` changes afterwards.
- R8: A trigger that arrives from the trigger edge up to and including the edge that sets done is ignored. The packet is unchanged, and no second sequence starts afterwards.
- R9: On the edge after the last word, `cfg_sel_n` rises and `cfg_data` returns to 0. `cfg_dir_n` rises on the following edge, and `seq_done` rises on the edge after that. `seq_done` is cleared on the next accepted trigger edge.
- R10: `seq_busy` is high from the trigger edge until the edge that sets `seq_done`, and `seq_done` and `seq_busy` are never high together.
- R11: `cfg_data` is 0 whenever `cfg_sel_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the block and the configuration port |
| rst | input | 1 | Synchronous reset, active high |
| trig | input | 1 | Request a warm reboot; sampled only in idle |
| rev_sel | input | 2 | Image number to boot from, sampled with the trigger |
| cfg_sel_n | output | 1 | Configuration port select, active low |
| cfg_dir_n | output | 1 | Configuration port direction, 0 = write |
| cfg_data | output | 32 | Configuration port write data, byte-mirrored |
| seq_done | output | 1 | Set after a completed sequence, cleared by the next trigger |
| seq_busy | output | 1 | A sequence is in progress |

## Verification
The checker relies on one assumption about the inputs: `rst` is a clean synchronous pulse and is not asserted in the middle of a packet. The stimulus keeps to this by resetting only at the start. Besides that, the checker takes nothing for granted about `trig` or `rev_sel`, because both are ignored outside idle.

The stimulus drives every image number. In each run it flips `rev_sel` right after the trigger. It also pulses extra triggers at every cycle offset of a sequence, up to the edge that sets done, so that no input combination falls outside what the block must tolerate.

// File: rtl/wb_seq_pkg.sv
package wb_seq_pkg;

    localparam int CFG_W   = 32;
    localparam int REV_W   = 2;
    localparam int ADDR_W  = 26;
    localparam int PKT_LEN = 8;
    localparam int IDX_W   = $clog2(PKT_LEN + 1);

    // Logical packet words, before byte-lane mirroring.
    localparam logic [CFG_W-1:0] W_DUMMY   = 32'hFFFF_FFFF;
    localparam logic [CFG_W-1:0] W_SYNC    = 32'hAA99_5566;
    localparam logic [CFG_W-1:0] W_NOOP    = 32'h2000_0000;
    localparam logic [CFG_W-1:0] W_HDR_WBA = 32'h3002_0001;
    localparam logic [CFG_W-1:0] W_HDR_CMD = 32'h3000_8001;
    localparam logic [CFG_W-1:0] W_REBOOT  = 32'h0000_000F;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_STREAM,
        ST_DROP,
        ST_FINISH
    } seq_state_e;

    typedef struct packed {
        seq_state_e       state;
        logic [IDX_W-1:0] idx;
        logic [REV_W-1:0] rev;
        logic             sel_n;
        logic             dir_n;
        logic [CFG_W-1:0] data;
        logic             done;
    } seq_regs_t;

endpackage

// File: rtl/wb_packet_rom.sv
module wb_packet_rom
    import wb_seq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [REV_W-1:0] rev,
    output logic [CFG_W-1:0] word
);

    localparam int PAD_W = CFG_W - REV_W - 1 - ADDR_W;

    logic [CFG_W-1:0] start_word;

    // Start-address word: image number above the pin enable and the address.
    assign start_word = {{PAD_W{1'b0}}, rev, 1'b1, START_ADDR};

    always_comb begin
        unique case (idx)
            IDX_W'(0): word = W_DUMMY;
            IDX_W'(1): word = W_SYNC;
            IDX_W'(2): word = W_NOOP;
            IDX_W'(3): word = W_HDR_WBA;
            IDX_W'(4): word = start_word;
            IDX_W'(5): word = W_HDR_CMD;
            IDX_W'(6): word = W_REBOOT;
            IDX_W'(7): word = W_NOOP;
            default:   word = '0;
        endcase
    end

endmodule

// File: rtl/wb_byte_mirror.sv
module wb_byte_mirror #(
    parameter int W = 32
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    localparam int NBYTES = W / 8;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        for (genvar i = 0; i < 8; i++) begin : g_bit
            assign dout[8*b + i] = din[8*b + 7 - i];
        end
    end

endmodule

// File: rtl/wb_seq_ctrl.sv
module wb_seq_ctrl
    import wb_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    input  logic [REV_W-1:0] rev_sel,
    input  logic [CFG_W-1:0] lane_word,
    output logic [IDX_W-1:0] word_idx,
    output logic [REV_W-1:0] rev_hold,
    output logic             cfg_sel_n,
    output logic             cfg_dir_n,
    output logic [CFG_W-1:0] cfg_data,
    output logic             seq_done,
    output logic             seq_busy
);

    localparam seq_regs_t REGS_RST = '{
        state: ST_IDLE,
        idx:   '0,
        rev:   '0,
        sel_n: 1'b1,
        dir_n: 1'b1,
        data:  '0,
        done:  1'b0
    };

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_LEN);

    seq_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.state)
            ST_IDLE: begin
                if (trig) begin
                    regs_d.state = ST_ARM;
                    regs_d.dir_n = 1'b0;
                    regs_d.rev   = rev_sel;
                    regs_d.idx   = '0;
                    regs_d.done  = 1'b0;
                end
            end
            ST_ARM: begin
                regs_d.state = ST_STREAM;
                regs_d.sel_n = 1'b0;
                regs_d.data  = lane_word;
                regs_d.idx   = regs_q.idx + 1'b1;
            end
            ST_STREAM: begin
                if (regs_q.idx == LAST_IDX) begin
                    regs_d.state = ST_DROP;
                    regs_d.sel_n = 1'b1;
                    regs_d.data  = '0;
                end else begin
                    regs_d.data = lane_word;
                    regs_d.idx  = regs_q.idx + 1'b1;
                end
            end
            ST_DROP: begin
                regs_d.state = ST_FINISH;
                regs_d.dir_n = 1'b1;
            end
            ST_FINISH: begin
                regs_d.state = ST_IDLE;
                regs_d.done  = 1'b1;
            end
            default: regs_d = REGS_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= REGS_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign word_idx  = regs_q.idx;
    assign rev_hold  = regs_q.rev;
    assign cfg_sel_n = regs_q.sel_n;
    assign cfg_dir_n = regs_q.dir_n;
    assign cfg_data  = regs_q.data;
    assign seq_done  = regs_q.done;
    assign seq_busy  = (regs_q.state != ST_IDLE);

endmodule

// File: rtl/warm_boot_seq.sv
module warm_boot_seq
    import wb_seq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    input  logic [REV_W-1:0] rev_sel,
    output logic             cfg_sel_n,
    output logic             cfg_dir_n,
    output logic [CFG_W-1:0] cfg_data,
    output logic             seq_done,
    output logic             seq_busy
);

    logic [IDX_W-1:0] word_idx;
    logic [REV_W-1:0] rev_hold;
    logic [CFG_W-1:0] logic_word;
    logic [CFG_W-1:0] lane_word;

    wb_packet_rom #(
        .START_ADDR(START_ADDR)
    ) u_rom (
        .idx  (word_idx),
        .rev  (rev_hold),
        .word (logic_word)
    );

    wb_byte_mirror #(
        .W(CFG_W)
    ) u_mirror (
        .din  (logic_word),
        .dout (lane_word)
    );

    wb_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .trig      (trig),
        .rev_sel   (rev_sel),
        .lane_word (lane_word),
        .word_idx  (word_idx),
        .rev_hold  (rev_hold),
        .cfg_sel_n (cfg_sel_n),
        .cfg_dir_n (cfg_dir_n),
        .cfg_data  (cfg_data),
        .seq_done  (seq_done),
        .seq_busy  (seq_busy)
    );

endmodule

// File: rtl/wb_seq_chk.sv
module wb_seq_chk
    import wb_seq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cfg_sel_n,
    input logic             cfg_dir_n,
    input logic [CFG_W-1:0] cfg_data,
    input logic             seq_done,
    input logic             seq_busy
);

    localparam int CNT_W = IDX_W + 1;

    // Count of consecutive earlier cycles with select low.
    logic [CNT_W-1:0] low_cnt_q;

    always_ff @(posedge clk) begin
        if (rst || cfg_sel_n) begin
            low_cnt_q <= '0;
        end else begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    // R3: select and direction never move on the same edge
    p_no_joint_edge_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_sel_n) |-> $stable(cfg_dir_n));

    // R3: select low only while writing
    p_sel_needs_write_r3: assert property (@(posedge clk) disable iff (rst)
        !cfg_sel_n |-> !cfg_dir_n);

    // R4: at most eight words per select window
    p_window_bound_r4: assert property (@(posedge clk) disable iff (rst)
        !cfg_sel_n |-> (low_cnt_q < CNT_W'(PKT_LEN)));

    // R4: a window always closes after exactly eight words
    p_window_exact_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_sel_n) |-> (low_cnt_q == CNT_W'(PKT_LEN)));

    // R5: first two lane words are the mirrored dummy and sync words
    p_first_word_r5: assert property (@(posedge clk) disable iff (rst)
        (!cfg_sel_n && low_cnt_q == '0) |-> (cfg_data == 32'hFFFF_FFFF));

    p_sync_word_r5: assert property (@(posedge clk) disable iff (rst)
        (!cfg_sel_n && low_cnt_q == CNT_W'(1)) |-> (cfg_data == 32'h5599_AA66));

    // R9: done rises only after direction has been released
    p_done_after_release_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_done) |-> ($past(cfg_dir_n) && cfg_sel_n));

    // R10: busy and done are exclusive
    p_busy_done_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(seq_busy && seq_done));

    // R11: data bus quiet while not selected
    p_quiet_bus_r11: assert property (@(posedge clk) disable iff (rst)
        cfg_sel_n |-> (cfg_data == '0));

endmodule

bind warm_boot_seq wb_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_sel_n (cfg_sel_n),
    .cfg_dir_n (cfg_dir_n),
    .cfg_data  (cfg_data),
    .seq_done  (seq_done),
    .seq_busy  (seq_busy)
);

// File: tb/sim_warm_boot_seq.sv
`timescale 1ns/1ps
module sim_warm_boot_seq;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        trig;
    logic [1:0]  rev_sel;
    logic        cfg_sel_n;
    logic        cfg_dir_n;
    logic [31:0] cfg_data;
    logic        seq_done;
    logic        seq_busy;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    warm_boot_seq u0 (
        .clk       (clk),
        .rst       (rst),
        .trig      (trig),
        .rev_sel   (rev_sel),
        .cfg_sel_n (cfg_sel_n),
        .cfg_dir_n (cfg_dir_n),
        .cfg_data  (cfg_data),
        .seq_done  (seq_done),
        .seq_busy  (seq_busy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mirror(input logic [31:0] w);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) begin
            for (int i = 0; i < 8; i++) begin
                r[8*b + i] = w[8*b + 7 - i];
            end
        end
        return r;
    endfunction

    function automatic logic [31:0] logical_word(input int k, input logic [1:0] rev);
        case (k)
            0: return 32'hFFFF_FFFF;
            1: return 32'hAA99_5566;
            2: return 32'h2000_0000;
            3: return 32'h3002_0001;
            4: return (32'(rev) << 27) | (32'h1 << 26);
            5: return 32'h3000_8001;
            6: return 32'h0000_000F;
            default: return 32'h2000_0000;
        endcase
    endfunction

    function automatic logic [31:0] start_lane(input logic [1:0] rev);
        case (rev)
            2'd0: return 32'h2000_0000;
            2'd1: return 32'h3000_0000;
            2'd2: return 32'h2800_0000;
            default: return 32'h3800_0000;
        endcase
    endfunction

    task automatic rest_checks(input string req);
        check(req, {31'd0, cfg_sel_n}, 32'd1);
        check(req, {31'd0, cfg_dir_n}, 32'd1);
        check(req, cfg_data, 32'd0);
        check(req, {31'd0, seq_busy}, 32'd0);
    endtask

    // Called at a negedge with the block idle. inj_at < 0 means no extra trigger.
    task automatic run_seq(input logic [1:0] rev, input int inj_at);
        trig    = 1'b1;
        rev_sel = rev;
        @(negedge clk);
        trig    = 1'b0;
        rev_sel = ~rev;
        check("R3 dir low after trigger", {31'd0, cfg_dir_n}, 32'd0);
        check("R3 sel still high", {31'd0, cfg_sel_n}, 32'd1);
        check("R10 busy on trigger", {31'd0, seq_busy}, 32'd1);
        check("R9 done cleared", {31'd0, seq_done}, 32'd0);
        if (inj_at == 0) begin
            trig = 1'b1;
            rev_sel = ~rev;
        end
        for (int j = 1; j <= 11; j++) begin
            @(negedge clk);
            trig = 1'b0;
            if (j <= 8) begin
                check("R4 sel low in window", {31'd0, cfg_sel_n}, 32'd1 - 32'd1);
                check("R3 dir low in window", {31'd0, cfg_dir_n}, 32'd0);
                check("R5 R7 word", cfg_data, mirror(logical_word(j - 1, rev)));
                if (j == 5) check("R6 start word", cfg_data, start_lane(rev));
            end else if (j == 9) begin
                check("R9 sel released", {31'd0, cfg_sel_n}, 32'd1);
                check("R9 dir held", {31'd0, cfg_dir_n}, 32'd0);
                check("R11 data quiet", cfg_data, 32'd0);
            end else if (j == 10) begin
                check("R9 dir released", {31'd0, cfg_dir_n}, 32'd1);
                check("R9 done not yet", {31'd0, seq_done}, 32'd0);
                check("R10 busy", {31'd0, seq_busy}, 32'd1);
            end else begin
                check("R9 done set", {31'd0, seq_done}, 32'd1);
                check("R10 busy clear", {31'd0, seq_busy}, 32'd0);
            end
            if (inj_at == j && j <= 10) begin
                trig = 1'b1;
                rev_sel = ~rev;
            end
        end
        trig = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            rest_checks("R8 no restart");
            check("R9 done sticky", {31'd0, seq_done}, 32'd1);
        end
    endtask

    initial begin
        rst     = 1'b1;
        trig    = 1'b0;
        rev_sel = 2'd0;
        repeat (3) @(negedge clk);
        rest_checks("R1 reset");
        check("R1 done", {31'd0, seq_done}, 32'd0);
        rst = 1'b0;
        for (int k = 0; k < 16; k++) begin
            rev_sel = 2'(k);
            @(negedge clk);
            rest_checks("R2 idle");
        end
        check("R5 mirror sample", mirror(32'h3002_0001), 32'h0C40_0080);
        for (int r = 0; r < 4; r++) begin
            run_seq(2'(r), -1);
        end
        for (int r = 0; r < 4; r++) begin
            for (int inj = 0; inj <= 10; inj++) begin
                run_seq(2'(r), inj);
            end
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule